// File: doc/BRIEF.md
# Key Matrix Scanner with Typematic Repeat

This block scans an 8-column by 7-row key matrix once for every frame tick. Row inputs are active low. A scan starts with every column strobe held high, and the row inputs are sampled in that state to find which rows a joystick button is pulling low. The block then drives a single low strobe across the columns in turn. For each column it compares the sampled rows against a stored map of which keys are pressed. When a sampled bit differs from the stored bit, that key has been pressed (a make) or released (a break).

Three matrix positions act as modifier keys. Any change on one of them flips the matching flag, and these keys never produce a code. Each make on any other key emits one scan code. The most recently pressed key is armed for typematic repeat: it repeats after a long initial delay and then at a shorter interval. Both delays are counted in frame ticks. A downstream stage turns the codes into characters.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: After reset, col_o is all ones, code_valid_o is low, mods_o is zero and every key is taken as released, so a key that is held down reports a make on the first scan.
- R2: A tick_i seen while idle starts a scan. For one cycle col_o stays all ones, then exactly one bit is low, stepping from column 0 (col_o = 8'hFE) up to column 7 (8'h7F). col_o never has more than one bit low.
- R3: A newly pressed key at row r and column c emits code_o = r*8 + c (0 to 55) with a one-cycle code_valid_o, exactly once. A key that stays held reports no further make.
- R4: Releasing a key emits no code.
- R5: Row 6 holds the modifiers: column 7 toggles mods_o bit 0, column 4 toggles bit 1 and column 3 toggles bit 2. A press sets the flag and a release clears it. Modifier keys (codes 55, 52, 51) never appear on code_o.
- R6: A row that reads low in the all-high sample at the start of a scan is left out of change detection for that scan, so held keys on that row report nothing until the row is released. Row input bit 7 never affects any result.
- R7: After a make, the key repeats its code once 15 further ticks have passed, with no code in between.
- R8: After a repeat, the next repeat follows 5 ticks later, and so on while the key is held.
- R9: A make moves repeat to the new key. A break on the repeating key stops repeat. A break on any other key leaves the repeat timing unchanged.
- R10: Within one scan, codes appear in column order, and within a column in ascending row order. Every result of a scan is visible within 75 cycles after the tick. A tick that arrives during a scan is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Frame tick that starts one scan |
| row_i | input | 8 | Row inputs, active low; bit 7 is the comparator and is ignored |
| col_o | output | 8 | Column strobes, active low |
| code_valid_o | output | 1 | Pulse marking a valid code_o |
| code_o | output | 6 | Scan code, row*8 + column |
| mods_o | output | 3 | Modifier flags: bit 0 shift, bit 1 ctrl, bit 2 alt |

## Verification
The all-high sample takes one cycle after the tick. Each column then takes one cycle to sample plus one cycle per changed key and one cycle to advance. The repeat step takes one more cycle, and the output register adds a final cycle. In the worst case every code and modifier change of a scan is therefore registered within 75 cycles. The bench waits 80 cycles after each tick before it compares the event count, the last code and the flags, so nothing from one scan spills into the next. The strobe sequence is checked cycle by cycle. Repeat timing is checked by counting the events produced on each individual tick.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_JOY,
    ST_SAMPLE,
    ST_PROC,
    ST_REPEAT
  } scan_state_e;

  localparam int unsigned NUM_MODS = 3;
endpackage

// File: rtl/kbd_strobe_seq.sv
module kbd_strobe_seq
  import kbd_scan_pkg::*;
#(
  parameter int unsigned NUM_COLS = 8,
  localparam int unsigned COL_W = $clog2(NUM_COLS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                col_done_i,
  output scan_state_e         state_o,
  output logic [COL_W-1:0]    col_idx_o,
  output logic [NUM_COLS-1:0] col_o
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  scan_state_e state_q, state_d;
  logic [COL_W-1:0] col_q, col_d;
  logic scan_w;

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    unique case (state_q)
      ST_IDLE:   if (tick_i) state_d = ST_JOY;
      ST_JOY: begin
        state_d = ST_SAMPLE;
        col_d   = '0;
      end
      ST_SAMPLE: state_d = ST_PROC;
      ST_PROC: begin
        if (col_done_i) begin
          if (col_q == LAST_COL) begin
            state_d = ST_REPEAT;
          end else begin
            state_d = ST_SAMPLE;
            col_d   = col_q + COL_W'(1);
          end
        end
      end
      ST_REPEAT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
    end
  end

  assign scan_w = (state_q == ST_SAMPLE) || (state_q == ST_PROC);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_strobe
    assign col_o[c] = !(scan_w && (col_q == COL_W'(c)));
  end

  assign state_o   = state_q;
  assign col_idx_o = col_q;
endmodule

// File: rtl/kbd_key_map.sv
module kbd_key_map
  import kbd_scan_pkg::*;
#(
  parameter int unsigned NUM_COLS  = 8,
  parameter int unsigned NUM_ROWS  = 7,
  parameter int unsigned MOD_ROW   = 6,
  parameter int unsigned SHIFT_COL = 7,
  parameter int unsigned CTRL_COL  = 4,
  parameter int unsigned ALT_COL   = 3,
  localparam int unsigned COL_W    = $clog2(NUM_COLS),
  localparam int unsigned ROW_IN_W = NUM_ROWS + 1,
  localparam int unsigned ROW_W    = $clog2(ROW_IN_W),
  localparam int unsigned CODE_W   = $clog2(NUM_COLS * NUM_ROWS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  scan_state_e         state_i,
  input  logic [COL_W-1:0]    col_idx_i,
  input  logic [ROW_IN_W-1:0] row_i,
  output logic                col_done_o,
  output logic                evt_valid_o,
  output logic                evt_make_o,
  output logic [CODE_W-1:0]   evt_code_o,
  output logic [NUM_MODS-1:0] mods_o
);
  localparam int MOD_COL [NUM_MODS] = '{SHIFT_COL, CTRL_COL, ALT_COL};

  logic [NUM_COLS-1:0][NUM_ROWS-1:0] map_q;
  logic [NUM_ROWS-1:0] mask_q, pend_q;
  logic [ROW_IN_W-1:0] samp_q;
  logic [NUM_MODS-1:0] mods_q, mod_hit;
  logic [ROW_W-1:0]    sel_row;
  logic                any_pend, proc_w;

  always_comb begin
    sel_row = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (pend_q[r]) sel_row = ROW_W'(r);
    end
  end

  assign any_pend   = |pend_q;
  assign proc_w     = (state_i == ST_PROC);
  assign col_done_o = proc_w && !any_pend;
  assign evt_code_o = CODE_W'(int'(sel_row) * NUM_COLS + int'(col_idx_i));

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
    localparam int MCODE = MOD_ROW * NUM_COLS + MOD_COL[m];
    assign mod_hit[m] = (evt_code_o == CODE_W'(MCODE));
  end

  assign evt_valid_o = proc_w && any_pend && !(|mod_hit);
  assign evt_make_o  = !samp_q[sel_row];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q  <= '1;
      mask_q <= '0;
      pend_q <= '0;
      samp_q <= '1;
      mods_q <= '0;
    end else begin
      unique case (state_i)
        ST_JOY:    mask_q <= row_i[NUM_ROWS-1:0];
        ST_SAMPLE: begin
          samp_q <= row_i;
          pend_q <= (row_i[NUM_ROWS-1:0] ^ map_q[col_idx_i]) & mask_q;
        end
        ST_PROC: begin
          if (any_pend) begin
            pend_q[sel_row]           <= 1'b0;
            map_q[col_idx_i][sel_row] <= samp_q[sel_row];
            mods_q                    <= mods_q ^ mod_hit;
          end
        end
        default: ;
      endcase
    end
  end

  assign mods_o = mods_q;
endmodule

// File: rtl/kbd_repeat_ctrl.sv
module kbd_repeat_ctrl #(
  parameter int unsigned CODE_W     = 6,
  parameter int unsigned INIT_DELAY = 15,
  parameter int unsigned REP_DELAY  = 5,
  localparam int unsigned CNT_W = $clog2(INIT_DELAY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic              evt_make_i,
  input  logic [CODE_W-1:0] evt_code_i,
  input  logic              rep_phase_i,
  output logic              emit_o,
  output logic [CODE_W-1:0] emit_code_o
);
  logic              act_q, fresh_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q, cnt_dec;

  assign cnt_dec     = cnt_q - CNT_W'(1);
  assign emit_o      = rep_phase_i && act_q && !fresh_q && (cnt_dec == '0);
  assign emit_code_o = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      fresh_q <= 1'b0;
      code_q  <= '0;
      cnt_q   <= '0;
    end else if (evt_valid_i) begin
      if (evt_make_i) begin
        act_q   <= 1'b1;
        fresh_q <= 1'b1;
        code_q  <= evt_code_i;
        cnt_q   <= CNT_W'(INIT_DELAY);
      end else if (act_q && (evt_code_i == code_q)) begin
        act_q <= 1'b0;
      end
    end else if (rep_phase_i) begin
      fresh_q <= 1'b0;
      if (act_q && !fresh_q) begin
        cnt_q <= (cnt_dec == '0) ? CNT_W'(REP_DELAY) : cnt_dec;
      end
    end
  end
endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner
  import kbd_scan_pkg::*;
#(
  parameter int unsigned NUM_COLS   = 8,
  parameter int unsigned NUM_ROWS   = 7,
  parameter int unsigned INIT_DELAY = 15,
  parameter int unsigned REP_DELAY  = 5,
  localparam int unsigned ROW_IN_W  = NUM_ROWS + 1,
  localparam int unsigned COL_W     = $clog2(NUM_COLS),
  localparam int unsigned CODE_W    = $clog2(NUM_COLS * NUM_ROWS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [ROW_IN_W-1:0] row_i,
  output logic [NUM_COLS-1:0] col_o,
  output logic                code_valid_o,
  output logic [CODE_W-1:0]   code_o,
  output logic [NUM_MODS-1:0] mods_o
);
  scan_state_e       state_w;
  logic [COL_W-1:0]  col_idx_w;
  logic              col_done_w, evt_valid_w, evt_make_w, emit_w;
  logic [CODE_W-1:0] evt_code_w, emit_code_w;

  kbd_strobe_seq #(.NUM_COLS(NUM_COLS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .col_done_i (col_done_w),
    .state_o    (state_w),
    .col_idx_o  (col_idx_w),
    .col_o      (col_o)
  );

  kbd_key_map #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state_w),
    .col_idx_i   (col_idx_w),
    .row_i       (row_i),
    .col_done_o  (col_done_w),
    .evt_valid_o (evt_valid_w),
    .evt_make_o  (evt_make_w),
    .evt_code_o  (evt_code_w),
    .mods_o      (mods_o)
  );

  kbd_repeat_ctrl #(
    .CODE_W(CODE_W), .INIT_DELAY(INIT_DELAY), .REP_DELAY(REP_DELAY)
  ) u_rep (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_valid_i (evt_valid_w),
    .evt_make_i  (evt_make_w),
    .evt_code_i  (evt_code_w),
    .rep_phase_i (state_w == ST_REPEAT),
    .emit_o      (emit_w),
    .emit_code_o (emit_code_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_valid_o <= 1'b0;
      code_o       <= '0;
    end else begin
      code_valid_o <= (evt_valid_w && evt_make_w) || emit_w;
      if (emit_w)                         code_o <= emit_code_w;
      else if (evt_valid_w && evt_make_w) code_o <= evt_code_w;
    end
  end
endmodule

// File: rtl/kbd_matrix_scanner_chk.sv
module kbd_matrix_scanner_chk #(
  parameter int unsigned NUM_COLS = 8,
  parameter int unsigned NUM_ROWS = 7,
  localparam int unsigned CODE_W  = $clog2(NUM_COLS * NUM_ROWS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_COLS-1:0] col_o,
  input logic                code_valid_o,
  input logic [CODE_W-1:0]   code_o,
  input logic [2:0]          mods_o
);
  localparam int NUM_KEYS = NUM_COLS * NUM_ROWS;
  localparam logic [NUM_COLS-1:0] FIRST = {{(NUM_COLS-1){1'b1}}, 1'b0};

  logic [NUM_COLS-1:0] col_q;
  logic [2:0]          mods_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '1;
      mods_q <= '0;
    end else begin
      col_q  <= col_o;
      mods_q <= mods_o;
    end
  end

  p_single_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~col_o) <= 1);

  p_strobe_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_q == '1 && col_o != '1) |-> col_o == FIRST);

  p_strobe_walk_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_q != '1 && col_o != '1 && col_o != col_q)
      |-> col_o == {col_q[NUM_COLS-2:0], 1'b1});

  p_code_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o |-> int'(code_o) < NUM_KEYS);

  p_no_mod_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o |-> (code_o != CODE_W'(55) && code_o != CODE_W'(52)
                      && code_o != CODE_W'(51)));

  p_mod_in_scan_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mods_o != mods_q) |-> col_q != '1);
endmodule

bind kbd_matrix_scanner kbd_matrix_scanner_chk #(
  .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .col_o        (col_o),
  .code_valid_o (code_valid_o),
  .code_o       (code_o),
  .mods_o       (mods_o)
);

// File: tb/kbd_matrix_scanner_bench.sv
`timescale 1ns/1ps
module kbd_matrix_scanner_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] row;
  logic [7:0] col;
  logic       cvalid;
  logic [5:0] code;
  logic [2:0] mods;

  logic [55:0] keys = '0;
  logic [6:0]  joy  = '0;
  logic        cmp  = 1'b0;

  int n_chk = 0, n_fail = 0;
  int ev_cnt = 0;
  int ev_last = -1;
  int ev_prev = -1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kbd_matrix_scanner u_kbd_matrix_scanner (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .row_i(row),
    .col_o(col), .code_valid_o(cvalid), .code_o(code), .mods_o(mods)
  );

  always_comb begin
    for (int r = 0; r < 7; r++) begin
      row[r] = !joy[r];
      for (int c = 0; c < 8; c++)
        if (!col[c] && keys[r*8+c]) row[r] = 1'b0;
    end
    row[7] = cmp;
  end

  always @(posedge clk) begin
    if (rst_n && cvalid) begin
      ev_prev = ev_last;
      ev_last = int'(code);
      ev_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick(output int n);
    int base;
    base = ev_cnt;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (80) @(negedge clk);
    n = ev_cnt - base;
  endtask

  typedef struct packed {
    logic [55:0] keys;
    logic [6:0]  joy;
    logic [1:0]  n;
    logic [5:0]  code;
    logic [2:0]  mods;
  } vec_t;

  localparam logic [55:0] K0 = 56'd1, K1 = 56'd1 << 1, K8 = 56'd1 << 8;
  localparam logic [55:0] K9 = 56'd1 << 9, K10 = 56'd1 << 10, K17 = 56'd1 << 17;
  localparam logic [55:0] K20 = 56'd1 << 20, K51 = 56'd1 << 51;
  localparam logic [55:0] K52 = 56'd1 << 52, K55 = 56'd1 << 55;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{'0,              7'h00, 2'd0, 6'd0,  3'd0},  // idle R3
    '{K10,             7'h00, 2'd1, 6'd10, 3'd0},  // make R3
    '{K10|K20,         7'h00, 2'd1, 6'd20, 3'd0},  // held no remake R3
    '{K20,             7'h00, 2'd0, 6'd0,  3'd0},  // break R4
    '{'0,              7'h00, 2'd0, 6'd0,  3'd0},  // break R4
    '{K55,             7'h00, 2'd0, 6'd0,  3'd1},  // shift R5
    '{K55|K52|K51,     7'h00, 2'd0, 6'd0,  3'd7},  // all mods R5
    '{'0,              7'h00, 2'd0, 6'd0,  3'd0},  // release mods R5
    '{K0|K1,           7'h00, 2'd2, 6'd1,  3'd0},  // column order R10
    '{'0,              7'h00, 2'd0, 6'd0,  3'd0},
    '{K8,              7'h02, 2'd0, 6'd0,  3'd0},  // masked row R6
    '{K8,              7'h00, 2'd1, 6'd8,  3'd0},  // unmasked R6
    '{K8|K9|K17,       7'h00, 2'd2, 6'd17, 3'd0},  // row order R10
    '{'0,              7'h00, 2'd0, 6'd0,  3'd0}
  };

  initial begin
    int n;
    int k;
    int lows;
    bit seq_ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(col == 8'hFF, "R1 col", int'(col), 255);
    check(!cvalid, "R1 valid", int'(cvalid), 0);
    check(mods == 3'd0, "R1 mods", int'(mods), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 strobe walk
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    check(col == 8'hFF, "R2 joystick sample", int'(col), 255);
    seq_ok = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (col != ~(8'd1 << c)) seq_ok = 1'b0;
      @(negedge clk);
      if (col != ~(8'd1 << c)) seq_ok = 1'b0;
    end
    check(seq_ok, "R2 walk", int'(col), 127);
    repeat (80) @(negedge clk);

    // R1 first scan after reset sees held key as make
    keys = K10;
    do_tick(n);
    check(n == 1 && ev_last == 10, "R1 held key at reset", n, 1);
    keys = '0;
    do_tick(n);

    // table walk
    for (int i = 0; i < NV; i++) begin
      keys = VT[i].keys;
      joy  = VT[i].joy;
      cmp  = i[0];
      do_tick(n);
      check(n == int'(VT[i].n), $sformatf("R3 vec%0d count", i), n, int'(VT[i].n));
      if (VT[i].n != 0)
        check(ev_last == int'(VT[i].code), $sformatf("R3 vec%0d code", i),
              ev_last, int'(VT[i].code));
      if (VT[i].n == 2)
        check(ev_prev < ev_last, $sformatf("R10 vec%0d order", i), ev_prev, ev_last);
      check(mods == VT[i].mods, $sformatf("R5 vec%0d mods", i), int'(mods), int'(VT[i].mods));
    end
    joy = '0;

    // R7 / R8 repeat timing
    keys = 56'd1 << 33;
    do_tick(n);
    check(n == 1 && ev_last == 33, "R7 make", n, 1);
    k = 0;
    for (int t = 1; t <= 14; t++) begin do_tick(n); k += n; end
    check(k == 0, "R7 quiet before first repeat", k, 0);
    do_tick(n);
    check(n == 1 && ev_last == 33, "R7 first repeat", n, 1);
    k = 0;
    for (int t = 1; t <= 4; t++) begin do_tick(n); k += n; end
    check(k == 0, "R8 quiet between repeats", k, 0);
    do_tick(n);
    check(n == 1 && ev_last == 33, "R8 second repeat", n, 1);

    // R9 newest key, break of other key
    keys = (56'd1 << 33) | (56'd1 << 40);
    do_tick(n);
    check(n == 1 && ev_last == 40, "R9 switch to newest", ev_last, 40);
    keys = 56'd1 << 40;
    k = 0;
    for (int t = 1; t <= 14; t++) begin do_tick(n); k += n; end
    check(k == 0, "R9 other break keeps timing", k, 0);
    do_tick(n);
    check(n == 1 && ev_last == 40, "R9 repeat new key", n, 1);
    keys = '0;
    k = 0;
    for (int t = 1; t <= 20; t++) begin do_tick(n); k += n; end
    check(k == 0, "R9 break cancels repeat", k, 0);

    // R10 tick during scan ignored
    keys = 56'd1 << 5;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (4) @(negedge clk);
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (80) @(negedge clk);
    lows = 0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (col != 8'hFF) lows++;
    end
    check(lows == 0, "R10 second tick ignored", lows, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule